// File: doc/BRIEF.md
# Pipeline Stall Attribution Event Generator

This block looks at a set of per-cycle pipeline status flags and decides, for every clock cycle, which stall categories that cycle belongs to. It then drives one single-cycle event pulse per category towards a performance counter block. The categories cover three areas. Front-end starvation is an empty instruction queue, split by its cause. Execute interlocks are split by the instruction class that causes them. Write-back-stage stalls are split into load misses and stores.

Within each area the block settles overlaps with fixed priority and exclusion rules, so each cycle is charged to at most one cause per area. Interlock cycles that coincide with a write-back stall are not counted as interlocks. All event outputs are registered. A pulse therefore appears in the cycle after the flags that qualify it.

Top module: `stall_attr_gen`

## Requirements
- R1: Event bit 0 (`stallEvt[0]`) pulses when `qEmpty` is set and none of `recentUtlbMiss`, `icacheMissBusy`, `iutlbMissBusy` or `predecodeErrBusy` is set.
- R2: Event bit 1 pulses when `qEmpty` and `icacheMissBusy` are both set. An instruction cache miss has top priority among front-end causes.
- R3: Event bit 2 pulses when `qEmpty` and `iutlbMissBusy` are set and `icacheMissBusy` is clear.
- R4: Event bit 3 pulses when `qEmpty` and `predecodeErrBusy` are set and both `icacheMissBusy` and `iutlbMissBusy` are clear. At most one of bits 0 to 3 is set in any cycle.
- R5: Event bit 4 pulses for an `interlock` with neither `ilkSimdFp` nor `ilkAgu` set.
- R6: Event bit 5 pulses for an `interlock` with `ilkAgu` set and `ilkSimdFp` clear.
- R7: Event bit 6 pulses for an `interlock` with `ilkSimdFp` set, whatever the value of `ilkAgu`. At most one of bits 4 to 6 is set in any cycle.
- R8: When `wbStall` is set, bits 4, 5 and 6 stay low in the following cycle, whatever the interlock flags are.
- R9: Event bit 7 pulses when `wbStall` and `wbLoadMiss` are both set.
- R10: Event bit 8 pulses when `wbStall` and `wbStore` are set and `wbLoadMiss` is clear.
- R11: The cause flags have no effect while their own qualifying flag is clear. Front-end causes need `qEmpty`, interlock causes need `interlock`, and write-back causes need `wbStall`.
- R12: Each output bit reflects the flags sampled at the previous rising clock edge. While the active-low `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qEmpty | input | 1 | Instruction queue is empty this cycle |
| recentUtlbMiss | input | 1 | A micro-TLB miss occurred recently |
| icacheMissBusy | input | 1 | Instruction cache miss being serviced |
| iutlbMissBusy | input | 1 | Instruction micro-TLB miss being serviced |
| predecodeErrBusy | input | 1 | Pre-decode error being handled |
| interlock | input | 1 | Execute interlock present |
| ilkSimdFp | input | 1 | Interlock caused by a SIMD/floating-point instruction |
| ilkAgu | input | 1 | Interlock caused by a load/store awaiting address operands |
| wbStall | input | 1 | Write-back stage stalled |
| wbLoadMiss | input | 1 | Write-back stall caused by a load miss |
| wbStore | input | 1 | Write-back stall caused by a store |
| stallEvt | output | 9 | Registered event pulses, bit i is category i |

## Verification
The overlap that matters most is between an interlock and a write-back stall in the same cycle. In that case the interlock categories must give way, while the write-back categories still count. The stimulus pushes both `interlock` and `wbStall` high often, in directed cases and in a random stream with biased flag probabilities. Each result is judged against a bench model that applies the exclusion rule on its own. Overlapping front-end causes, and overlapping interlock or write-back causes, are provoked in the same way, and the model applies the priority order to them.

// File: rtl/stall_attr_pkg.sv
package stall_attr_pkg;

  localparam int NUM_EVT = 9;

  // Strobe bundle from classifier to register stage.
  // First field is the MSB, so casting to a vector puts feIdle at bit 0.
  typedef struct packed {
    logic wbStoreHit;
    logic wbLoadHit;
    logic ilkSimd;
    logic ilkAddr;
    logic ilkOther;
    logic fePredec;
    logic feItlb;
    logic feIcache;
    logic feIdle;
  } stallStrobes_t;

endpackage

// File: rtl/stall_attr_ctrl.sv
module stall_attr_ctrl
  import stall_attr_pkg::*;
(
  input  logic          qEmpty,
  input  logic          recentUtlbMiss,
  input  logic          icacheMissBusy,
  input  logic          iutlbMissBusy,
  input  logic          predecodeErrBusy,
  input  logic          interlock,
  input  logic          ilkSimdFp,
  input  logic          ilkAgu,
  input  logic          wbStall,
  input  logic          wbLoadMiss,
  input  logic          wbStore,
  output stallStrobes_t strobes
);

  logic feAnyCause;
  logic ilkQualified;

  // Front end: cache miss first, then micro-TLB, then pre-decode.
  always_comb begin
    feAnyCause = recentUtlbMiss | icacheMissBusy | iutlbMissBusy | predecodeErrBusy;
    strobes.feIdle   = qEmpty & ~feAnyCause;
    strobes.feIcache = qEmpty & icacheMissBusy;
    strobes.feItlb   = qEmpty & iutlbMissBusy & ~icacheMissBusy;
    strobes.fePredec = qEmpty & predecodeErrBusy & ~icacheMissBusy & ~iutlbMissBusy;
  end

  // Interlocks: removed under a write-back stall; SIMD/FP wins over AGU wait.
  always_comb begin
    ilkQualified     = interlock & ~wbStall;
    strobes.ilkSimd  = ilkQualified & ilkSimdFp;
    strobes.ilkAddr  = ilkQualified & ilkAgu & ~ilkSimdFp;
    strobes.ilkOther = ilkQualified & ~ilkAgu & ~ilkSimdFp;
  end

  // Write-back stalls: load miss wins over store.
  always_comb begin
    strobes.wbLoadHit  = wbStall & wbLoadMiss;
    strobes.wbStoreHit = wbStall & wbStore & ~wbLoadMiss;
  end

endmodule

// File: rtl/stall_attr_dp.sv
module stall_attr_dp
  import stall_attr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  stallStrobes_t      strobes,
  output logic [NUM_EVT-1:0] evtOut
);

  logic [NUM_EVT-1:0] nextVec;
  assign nextVec = strobes;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evtReg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evtOut[i] <= 1'b0;
      else        evtOut[i] <= nextVec[i];
    end
  end

endmodule

// File: rtl/stall_attr_gen.sv
module stall_attr_gen
  import stall_attr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qEmpty,
  input  logic               recentUtlbMiss,
  input  logic               icacheMissBusy,
  input  logic               iutlbMissBusy,
  input  logic               predecodeErrBusy,
  input  logic               interlock,
  input  logic               ilkSimdFp,
  input  logic               ilkAgu,
  input  logic               wbStall,
  input  logic               wbLoadMiss,
  input  logic               wbStore,
  output logic [NUM_EVT-1:0] stallEvt
);

  stallStrobes_t strobes;

  stall_attr_ctrl u_ctrl (
    .qEmpty           (qEmpty),
    .recentUtlbMiss   (recentUtlbMiss),
    .icacheMissBusy   (icacheMissBusy),
    .iutlbMissBusy    (iutlbMissBusy),
    .predecodeErrBusy (predecodeErrBusy),
    .interlock        (interlock),
    .ilkSimdFp        (ilkSimdFp),
    .ilkAgu           (ilkAgu),
    .wbStall          (wbStall),
    .wbLoadMiss       (wbLoadMiss),
    .wbStore          (wbStore),
    .strobes          (strobes)
  );

  stall_attr_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .evtOut  (stallEvt)
  );

endmodule

// File: rtl/stall_attr_chk.sv
module stall_attr_chk
  import stall_attr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               qEmpty,
  input logic               recentUtlbMiss,
  input logic               icacheMissBusy,
  input logic               iutlbMissBusy,
  input logic               predecodeErrBusy,
  input logic               interlock,
  input logic               ilkSimdFp,
  input logic               ilkAgu,
  input logic               wbStall,
  input logic               wbLoadMiss,
  input logic               wbStore,
  input logic [NUM_EVT-1:0] stallEvt
);

  p_fe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stallEvt[3:0]));

  p_ilk_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stallEvt[6:4]));

  p_idle_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stallEvt[0] |-> $past(qEmpty && !recentUtlbMiss && !icacheMissBusy
                          && !iutlbMissBusy && !predecodeErrBusy));

  p_icache_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stallEvt[1] |-> $past(qEmpty && icacheMissBusy));

  p_wb_blocks_ilk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wbStall) |-> (stallEvt[6:4] == 3'b000));

  p_load_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wbStall && wbLoadMiss)) |-> stallEvt[7]);

  p_store_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stallEvt[8] |-> $past(wbStall && wbStore && !wbLoadMiss));

  p_ilk_needs_parent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!interlock) |-> (stallEvt[6:4] == 3'b000));

endmodule

bind stall_attr_gen stall_attr_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .qEmpty           (qEmpty),
  .recentUtlbMiss   (recentUtlbMiss),
  .icacheMissBusy   (icacheMissBusy),
  .iutlbMissBusy    (iutlbMissBusy),
  .predecodeErrBusy (predecodeErrBusy),
  .interlock        (interlock),
  .ilkSimdFp        (ilkSimdFp),
  .ilkAgu           (ilkAgu),
  .wbStall          (wbStall),
  .wbLoadMiss       (wbLoadMiss),
  .wbStore          (wbStore),
  .stallEvt         (stallEvt)
);

// File: tb/tb_stall_attr_gen.sv
module tb_stall_attr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qEmpty = 0, recentUtlbMiss = 0, icacheMissBusy = 0, iutlbMissBusy = 0;
  logic predecodeErrBusy = 0, interlock = 0, ilkSimdFp = 0, ilkAgu = 0;
  logic wbStall = 0, wbLoadMiss = 0, wbStore = 0;
  logic [8:0] stallEvt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stall_attr_gen dut (
    .clk(clk), .rst_n(rst_n), .qEmpty(qEmpty), .recentUtlbMiss(recentUtlbMiss),
    .icacheMissBusy(icacheMissBusy), .iutlbMissBusy(iutlbMissBusy),
    .predecodeErrBusy(predecodeErrBusy), .interlock(interlock),
    .ilkSimdFp(ilkSimdFp), .ilkAgu(ilkAgu), .wbStall(wbStall),
    .wbLoadMiss(wbLoadMiss), .wbStore(wbStore), .stallEvt(stallEvt)
  );

  // Reference model built from the requirement list.
  function automatic logic [8:0] model(logic [10:0] f);
    logic qe, ru, ic, it, pd, il, sf, ag, ws, lm, st;
    logic [8:0] e;
    {qe, ru, ic, it, pd, il, sf, ag, ws, lm, st} = f;
    e = '0;
    e[0] = qe && !ru && !ic && !it && !pd;         // R1
    e[1] = qe && ic;                               // R2
    e[2] = qe && it && !ic;                        // R3
    e[3] = qe && pd && !ic && !it;                 // R4
    if (il && !ws) begin                           // R8
      if (sf)      e[6] = 1'b1;                    // R7
      else if (ag) e[5] = 1'b1;                    // R6
      else         e[4] = 1'b1;                    // R5
    end
    e[7] = ws && lm;                               // R9
    e[8] = ws && st && !lm;                        // R10
    return e;
  endfunction

  function automatic string reqOf(int b);
    case (b)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; 7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic applyFlags(logic [10:0] f);
    {qEmpty, recentUtlbMiss, icacheMissBusy, iutlbMissBusy, predecodeErrBusy,
     interlock, ilkSimdFp, ilkAgu, wbStall, wbLoadMiss, wbStore} = f;
  endtask

  // Drive at the falling edge, let one rising edge register it, sample 1 after.
  task automatic runCase(logic [10:0] f, string tag);
    logic [8:0] exp;
    string who;
    @(negedge clk);
    applyFlags(f);
    exp = model(f);
    @(posedge clk);
    #1;
    checks++;
    if (stallEvt !== exp) begin
      errors++;
      who = tag;
      if (who == "") begin
        for (int b = 0; b < 9; b++)
          if (stallEvt[b] !== exp[b] && who == "") who = reqOf(b);
      end
      $display("FAIL %s: flags=%b actual=%b expected=%b", who, f, stallEvt, exp);
    end
  endtask

  function automatic logic bias(int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        errors++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [10:0] f;
    void'($urandom(32'd20240611));
    // R12: held in reset with all flags set, outputs must stay zero
    applyFlags(11'h7FF);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (stallEvt !== 9'd0) begin
      errors++;
      $display("FAIL R12: actual=%b expected=%b", stallEvt, 9'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    applyFlags('0);

    // Flag order: qe ru ic it pd il sf ag ws lm st
    runCase(11'b10000000000, "R1");   // plain idle queue
    runCase(11'b11000000000, "R1");   // recent uTLB miss removes idle
    runCase(11'b11110000000, "R2");   // cache miss beats uTLB
    runCase(11'b10011000000, "R3");   // uTLB beats pre-decode
    runCase(11'b10001000000, "R4");   // pre-decode alone
    runCase(11'b00000100000, "R5");   // generic interlock
    runCase(11'b00000101000, "R6");   // AGU wait
    runCase(11'b00000111000, "R7");   // SIMD beats AGU
    runCase(11'b00000111100, "R8");   // interlock under wb stall
    runCase(11'b00000100110, "R8");   // generic interlock hidden, load miss counts
    runCase(11'b00000000111, "R9");   // load miss beats store
    runCase(11'b00000000101, "R10");  // store alone
    runCase(11'b01111011011, "R11");  // causes without parents
    // R12: single-cycle pulse then back to zero
    runCase(11'b10000000000, "R12");
    runCase(11'b00000000000, "R12");

    for (int n = 0; n < N_RANDOM; n++) begin
      f = {bias(50), bias(30), bias(30), bias(30), bias(30),
           bias(60), bias(35), bias(35), bias(45), bias(40), bias(40)};
      runCase(f, "");
    end

    // R12: reset mid-run clears outputs asynchronously
    @(negedge clk);
    applyFlags(11'h7FF);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    checks++;
    if (stallEvt !== 9'd0) begin
      errors++;
      $display("FAIL R12: actual=%b expected=%b", stallEvt, 9'd0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule